// File: doc/BRIEF.md
# Counter Overflow Status View

This block produces the read value of a read-only status register through which supervisor software learns which hardware event counters have overflowed. Each event selector carries a sticky overflow flag. The block gathers those flags into one word, where bit X stands for counter X, and gates every bit with the counter-enable masks that also govern access to the matching counter.

The gating depends on the privilege level and on whether a guest is running. In machine level, and in supervisor level without virtualization, a bit is visible only when the machine counter-enable bit at the same position is set. For a virtualized supervisor, both the machine bit and the hypervisor counter-enable bit must be set. Every bit that fails this test reads as zero and does not raise a trap. Counter positions with no event selector behind them always read zero.

The read path is purely combinational from the flags, the masks, the mode and the CSR address. A flag that changes is therefore seen on the next read. The clock and reset serve only the bound property checker.

Top module: `overflow_shadow`

## Requirements
- R1: With `priv_lvl` = 2'b11 (machine), `ovf_view` bit X equals `ovf_flags` bit X AND `mach_cnt_en` bit X. `virt_on` and `hyp_cnt_en` have no effect.
- R2: With `priv_lvl` = 2'b01 and `virt_on` = 0 (supervisor), `ovf_view` bit X equals `ovf_flags` bit X AND `mach_cnt_en` bit X. `hyp_cnt_en` has no effect.
- R3: With `priv_lvl` = 2'b01 and `virt_on` = 1 (virtual supervisor), `ovf_view` bit X equals `ovf_flags` bit X AND `mach_cnt_en` bit X AND `hyp_cnt_en` bit X.
- R4: With `priv_lvl` = 2'b00 (user, with or without `virt_on`) or with the reserved value 2'b10, `ovf_view` is all zeros.
- R5: Bits 0, 1 and 2 of `ovf_view` (positions below `FIRST_IMPL` = 3) always read zero, whatever the flags and masks.
- R6: `csr_hit` is 1 exactly when `csr_addr` equals 12'hD33. `csr_rdata` equals `ovf_view` when `csr_hit` is 1, and is zero otherwise.
- R7: `ovf_view` follows a change of `ovf_flags` in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the bound checker |
| rst_n | input | 1 | Active-low reset for the bound checker |
| priv_lvl | input | 2 | Current privilege level: 3 machine, 1 supervisor, 0 user, 2 reserved |
| virt_on | input | 1 | A guest (virtualized) context is running |
| ovf_flags | input | 32 | Overflow flags, one per event selector |
| mach_cnt_en | input | 32 | Machine counter-enable mask |
| hyp_cnt_en | input | 32 | Hypervisor counter-enable mask |
| csr_addr | input | 12 | CSR address being read |
| ovf_view | output | 32 | Masked overflow status word |
| csr_hit | output | 1 | The address selects this register |
| csr_rdata | output | 32 | Read data, zero on an address miss |

## Verification
The bench builds the block with its defaults: 32 counter positions, the first implemented position at 3, and the address 12'hD33. These values put the unimplemented low-bit hole and the full 32-bit mask width within reach of the tests. With them, the vector table can pit the two enable masks against each other in every mode, including cases where they disagree only in the top byte or only in the low bits. Directed tests then move the address one step away from the match and change a single flag between two reads.

// File: rtl/ovf_shadow_pkg.sv
package ovf_shadow_pkg;

    localparam logic [1:0] PRIV_USER  = 2'b00;
    localparam logic [1:0] PRIV_SUPER = 2'b01;
    localparam logic [1:0] PRIV_RSVD  = 2'b10;
    localparam logic [1:0] PRIV_MACH  = 2'b11;

    // Which enable masks decide visibility
    typedef enum logic [1:0] {
        SEL_NONE  = 2'b00,   // everything hidden
        SEL_MACH  = 2'b01,   // machine mask only
        SEL_GUEST = 2'b10    // machine and hypervisor masks
    } view_sel_e;

endpackage

// File: rtl/ovf_mode_decode.sv
module ovf_mode_decode
    import ovf_shadow_pkg::*;
(
    input  logic [1:0] priv_lvl,
    input  logic       virt_on,
    output view_sel_e  view_sel
);

    always_comb begin
        unique case (priv_lvl)
            PRIV_MACH:  view_sel = SEL_MACH;
            PRIV_SUPER: view_sel = virt_on ? SEL_GUEST : SEL_MACH;
            PRIV_USER:  view_sel = SEL_NONE;
            PRIV_RSVD:  view_sel = SEL_NONE;
            default:    view_sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/ovf_bit_gate.sv
module ovf_bit_gate
    import ovf_shadow_pkg::*;
#(
    parameter int NUM_BITS   = 32,
    parameter int FIRST_IMPL = 3
) (
    input  view_sel_e             view_sel,
    input  logic [NUM_BITS-1:0]   flags,
    input  logic [NUM_BITS-1:0]   m_en,
    input  logic [NUM_BITS-1:0]   h_en,
    output logic [NUM_BITS-1:0]   view
);

    logic [NUM_BITS-1:0] bit_open;

    // One visibility decision per counter position; positions with no
    // event selector are tied shut.
    for (genvar i = 0; i < NUM_BITS; i++) begin : g_pos
        if (i < FIRST_IMPL) begin : g_absent
            assign bit_open[i] = 1'b0;
        end else begin : g_present
            always_comb begin
                unique case (view_sel)
                    SEL_MACH:  bit_open[i] = m_en[i];
                    SEL_GUEST: bit_open[i] = m_en[i] & h_en[i];
                    SEL_NONE:  bit_open[i] = 1'b0;
                    default:   bit_open[i] = 1'b0;
                endcase
            end
        end
        assign view[i] = flags[i] & bit_open[i];
    end

endmodule

// File: rtl/overflow_shadow.sv
module overflow_shadow
    import ovf_shadow_pkg::*;
#(
    parameter int           NUM_BITS   = 32,
    parameter int           FIRST_IMPL = 3,
    parameter int           ADDR_W     = 12,
    parameter logic [11:0]  REG_ADDR   = 12'hD33
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           priv_lvl,
    input  logic                 virt_on,
    input  logic [NUM_BITS-1:0]  ovf_flags,
    input  logic [NUM_BITS-1:0]  mach_cnt_en,
    input  logic [NUM_BITS-1:0]  hyp_cnt_en,
    input  logic [ADDR_W-1:0]    csr_addr,
    output logic [NUM_BITS-1:0]  ovf_view,
    output logic                 csr_hit,
    output logic [NUM_BITS-1:0]  csr_rdata
);

    localparam logic [ADDR_W-1:0] MATCH_ADDR = ADDR_W'(REG_ADDR);

    view_sel_e view_sel;

    ovf_mode_decode u_decode (
        .priv_lvl (priv_lvl),
        .virt_on  (virt_on),
        .view_sel (view_sel)
    );

    ovf_bit_gate #(
        .NUM_BITS   (NUM_BITS),
        .FIRST_IMPL (FIRST_IMPL)
    ) u_gate (
        .view_sel (view_sel),
        .flags    (ovf_flags),
        .m_en     (mach_cnt_en),
        .h_en     (hyp_cnt_en),
        .view     (ovf_view)
    );

    always_comb begin
        csr_hit   = (csr_addr == MATCH_ADDR);
        csr_rdata = csr_hit ? ovf_view : '0;
    end

endmodule

// File: rtl/overflow_shadow_chk.sv
module overflow_shadow_chk #(
    parameter int           NUM_BITS   = 32,
    parameter int           FIRST_IMPL = 3,
    parameter int           ADDR_W     = 12,
    parameter logic [11:0]  REG_ADDR   = 12'hD33
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           priv_lvl,
    input logic                 virt_on,
    input logic [NUM_BITS-1:0]  ovf_flags,
    input logic [NUM_BITS-1:0]  mach_cnt_en,
    input logic [NUM_BITS-1:0]  hyp_cnt_en,
    input logic [ADDR_W-1:0]    csr_addr,
    input logic [NUM_BITS-1:0]  ovf_view,
    input logic                 csr_hit,
    input logic [NUM_BITS-1:0]  csr_rdata
);

    function automatic logic [NUM_BITS-1:0] low_hole();
        logic [NUM_BITS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_BITS; i++) begin
            if (i < FIRST_IMPL) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [NUM_BITS-1:0] HOLE = low_hole();

    p_mach_view_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'b11) |-> (ovf_view == (ovf_flags & mach_cnt_en & ~HOLE)));

    p_super_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'b01 && !virt_on) |-> (ovf_view == (ovf_flags & mach_cnt_en & ~HOLE)));

    p_guest_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl == 2'b01 && virt_on) |->
        (ovf_view == (ovf_flags & mach_cnt_en & hyp_cnt_en & ~HOLE)));

    p_user_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_lvl[0] == 1'b0) |-> (ovf_view == '0));

    p_hole_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_view & HOLE) == '0);

    p_view_subset_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_view & ~ovf_flags) == '0);

    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_hit |-> (csr_rdata == '0));

    p_hit_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_addr == ADDR_W'(REG_ADDR)) |-> (csr_hit && csr_rdata == ovf_view));

endmodule

bind overflow_shadow overflow_shadow_chk #(
    .NUM_BITS   (NUM_BITS),
    .FIRST_IMPL (FIRST_IMPL),
    .ADDR_W     (ADDR_W),
    .REG_ADDR   (REG_ADDR)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_lvl    (priv_lvl),
    .virt_on     (virt_on),
    .ovf_flags   (ovf_flags),
    .mach_cnt_en (mach_cnt_en),
    .hyp_cnt_en  (hyp_cnt_en),
    .csr_addr    (csr_addr),
    .ovf_view    (ovf_view),
    .csr_hit     (csr_hit),
    .csr_rdata   (csr_rdata)
);

// File: tb/test_overflow_shadow.sv
module test_overflow_shadow;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv_lvl = 2'b00;
    logic        virt_on = 1'b0;
    logic [31:0] ovf_flags = '0;
    logic [31:0] mach_cnt_en = '0;
    logic [31:0] hyp_cnt_en = '0;
    logic [11:0] csr_addr = 12'h000;
    logic [31:0] ovf_view;
    logic        csr_hit;
    logic [31:0] csr_rdata;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    overflow_shadow i_overflow_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .priv_lvl    (priv_lvl),
        .virt_on     (virt_on),
        .ovf_flags   (ovf_flags),
        .mach_cnt_en (mach_cnt_en),
        .hyp_cnt_en  (hyp_cnt_en),
        .csr_addr    (csr_addr),
        .ovf_view    (ovf_view),
        .csr_hit     (csr_hit),
        .csr_rdata   (csr_rdata)
    );

    // Vector table: mode, virt, flags, machine mask, hypervisor mask, expected view
    localparam logic [1:0]  TV_PRIV [NV] = '{2'd3, 2'd3, 2'd1, 2'd1, 2'd1, 2'd0, 2'd0, 2'd2, 2'd1};
    localparam logic        TV_VIRT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [31:0] TV_FLAG [NV] = '{32'hFFFF_FFFF, 32'hF0F0_F0F8, 32'hAAAA_AAAA,
                                            32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000F};
    localparam logic [31:0] TV_MEN  [NV] = '{32'h0000_FFFF, 32'hFFFF_FFFF, 32'hFFFF_0000,
                                            32'hFF00_FF00, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};
    localparam logic [31:0] TV_HEN  [NV] = '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000,
                                            32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF,
                                            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
    localparam logic [31:0] TV_EXP  [NV] = '{32'h0000_FFF8, 32'hF0F0_F0F8, 32'hAAAA_0000,
                                            32'hF000_F000, 32'h1234_5678, 32'h0000_0000,
                                            32'h0000_0000, 32'h0000_0000, 32'h0000_0008};
    localparam string       TV_REQ  [NV] = '{"R1/R5", "R1", "R2", "R3", "R3", "R4",
                                            "R4", "R4", "R5"};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] p, input logic v, input logic [31:0] f,
                         input logic [31:0] m, input logic [31:0] h, input logic [11:0] a);
        @(negedge clk);
        priv_lvl = p; virt_on = v; ovf_flags = f;
        mach_cnt_en = m; hyp_cnt_en = h; csr_addr = a;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // reset state: all inputs zero, nothing visible (R4 user mode, R6 miss)
        check("R4 reset view", ovf_view, 32'h0);
        check("R6 reset hit", {31'h0, csr_hit}, 32'h0);
        check("R6 reset rdata", csr_rdata, 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            apply(TV_PRIV[k], TV_VIRT[k], TV_FLAG[k], TV_MEN[k], TV_HEN[k], 12'hD33);
            check(TV_REQ[k], ovf_view, TV_EXP[k]);
            check("R6 table rdata", csr_rdata, TV_EXP[k]);
        end

        // R2: hypervisor mask ignored for non-virtual supervisor
        apply(2'd1, 1'b0, 32'hFFFF_FFF8, 32'h00FF_00F8, 32'h0, 12'hD33);
        check("R2 hyp ignored", ovf_view, 32'h00FF_00F8);
        // R1: virt_on ignored in machine mode, hyp mask zero
        apply(2'd3, 1'b1, 32'h8000_0008, 32'h8000_0008, 32'h0, 12'hD33);
        check("R1 virt ignored", ovf_view, 32'h8000_0008);
        // R3: machine mask alone not enough for guest
        apply(2'd1, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 12'hD33);
        check("R3 hyp closed", ovf_view, 32'h0);
        // R5: low hole with everything open
        apply(2'd3, 1'b0, 32'h0000_0007, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 12'hD33);
        check("R5 low bits", ovf_view, 32'h0);

        // R6: address one step off in each direction
        apply(2'd3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 12'hD32);
        check("R6 miss low hit", {31'h0, csr_hit}, 32'h0);
        check("R6 miss low rdata", csr_rdata, 32'h0);
        check("R6 miss view intact", ovf_view, 32'hFFFF_FFF8);
        apply(2'd3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 12'hD34);
        check("R6 miss high rdata", csr_rdata, 32'h0);
        apply(2'd3, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 12'hD33);
        check("R6 hit", {31'h0, csr_hit}, 32'h1);

        // R7: a single flag changes and is seen at once
        apply(2'd1, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0, 12'hD33);
        check("R7 before", csr_rdata, 32'h0);
        @(negedge clk);
        ovf_flags = 32'h0010_0000;
        #1;
        check("R7 after", csr_rdata, 32'h0010_0000);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule